// File: doc/BRIEF.md
# Predicated Vector Element Loop Sequencer

This block expands one scalar operation into a run of per-element steps. After a start pulse it walks an outer element loop of VL iterations and, inside each element, a sub-vector loop of SUBVL iterations. For every step it presents a source element offset, a destination element offset and a sub-element offset to a downstream datapath, and marks the step either as a normal issue or as a zero-write. Steps that a predicate masks off without zeroing produce no step at all.

Two predicate lookups are used, one for the destination side and one for the source side. Each one can be disabled, which makes its mask read as all ones, or inverted. One predicate bit covers a whole sub-vector group. The source and destination offsets advance independently, so masked-off source and destination elements are skipped separately. In fail-on-first mode the datapath answers each issued step with a fail flag. The first failure ends the loop, and the index of the failing element becomes the effective vector length reported with done.

The downstream side throttles the sequencer with a ready input. While ready is low, nothing moves.

Top module: `vec_elem_seq`

## Requirements
- R1: After reset `busy_o`, `done_o` and `step_valid_o` are low, and the block stays idle until `start_i` is seen.
- R2: On an accepted start (block idle), the length, sub-vector code, masks, invert, zeroing and fail-on-first inputs are captured. For the rest of that run, changes on those inputs and further `start_i` pulses have no effect.
- R3: Steps come in element order. Within one element, `sub_offs_o` counts 0 up to SUBVL-1, where the `subvl_i` code 0b00, 0b01, 0b10 and 0b11 means 1, 2, 3 and 4. When an element is left, `sub_offs_o` returns to 0.
- R4: The effective predicate bit of element i on a side is `mask[i] ^ inv` when that side is enabled, and 1 otherwise. One bit governs every sub-step of that element.
- R5: When the destination bit is 0 and zeroing is set, the block emits SUBVL steps with `step_zero_o` high. When zeroing is clear, it emits no step for that element.
- R6: The source offset skips elements whose source bit is 0 and the destination offset skips elements whose destination bit is 0, each on its own. An issue step pairs a source whose bit is 1 with a destination whose bit is 1. The loop ends as soon as either offset reaches VL.
- R7: With fail-on-first set, `fail_i` high on an accepted issue step ends the loop, and no further step is produced. `eff_vl_o` then equals the failing destination element index. `fail_i` is ignored when fail-on-first is clear, and it is ignored on zero-write steps.
- R8: `done_o` is a one-cycle pulse in the cycle after the final accepted step, skip or failure. Without truncation, `eff_vl_o` equals VL.
- R9: While `ready_i` is low, the offsets, `step_valid_o` and `step_zero_o` hold their values.
- R10: A VL of 0 is treated as 1, and a VL above MAXVL is cut to MAXVL. VL=1 with SUBVL=1 and no predicates produces exactly one issue step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| vl_i | input | OFFS_W+1 | Requested vector length |
| subvl_i | input | 2 | Sub-vector length code (value minus one) |
| dst_pen_i | input | 1 | Destination predicate enable |
| dst_mask_i | input | MAXVL | Destination predicate mask |
| dst_inv_i | input | 1 | Invert destination predicate |
| src_pen_i | input | 1 | Source predicate enable |
| src_mask_i | input | MAXVL | Source predicate mask |
| src_inv_i | input | 1 | Invert source predicate |
| zeroing_i | input | 1 | Write zeros into masked-off destination elements |
| ffirst_i | input | 1 | Fail-on-first mode |
| ready_i | input | 1 | Downstream accepts a step this cycle |
| fail_i | input | 1 | Fail response for the current issue step |
| busy_o | output | 1 | Run in progress |
| step_valid_o | output | 1 | A step is presented |
| step_zero_o | output | 1 | The presented step is a zero-write |
| src_offs_o | output | IDX_W | Source element offset |
| dst_offs_o | output | IDX_W | Destination element offset |
| sub_offs_o | output | 2 | Sub-element offset |
| done_o | output | 1 | Run finished (one cycle) |
| eff_vl_o | output | OFFS_W | Effective vector length of the finished run |

## Verification
The bench targets twin-predicated runs, where the two offsets must drift apart. A design that advanced both offsets together would pair the wrong source with the wrong destination, or would end at the wrong element. Fail-on-first is hit at element zero, in the middle of a multi-sub-element group, and on a zero-write step. A design that counted the failing element, kept issuing after a failure, or honoured a fail on a zero write would report a wrong effective length or a wrong step count. Further runs cover out-of-range VL values, inverted masks, stalls driven by ready, and start or input changes in the middle of a run. A design that did not latch its configuration, or that let the offsets drift during a stall, would then produce a step sequence that differs from the one the bench computes.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } seq_state_e;

   typedef enum logic [1:0] {
      ACT_ISSUE    = 2'd0,
      ACT_ZERO     = 2'd1,
      ACT_SKIP_DST = 2'd2,
      ACT_SKIP_SRC = 2'd3
   } step_act_e;

   localparam int SUB_W = 2;

endpackage

// File: rtl/vseq_pred_bit.sv
module vseq_pred_bit #(
   parameter int MAXVL  = 16,
   parameter int OFFS_W = 5
) (
   input  logic              en_i,
   input  logic              inv_i,
   input  logic [MAXVL-1:0]  mask_i,
   input  logic [OFFS_W-1:0] idx_i,
   output logic              bit_o
);
   logic [MAXVL-1:0] shifted;

   always_comb begin
      shifted = mask_i >> idx_i;
      bit_o   = en_i ? (shifted[0] ^ inv_i) : 1'b1;
   end
endmodule

// File: rtl/vseq_offs_ctr.sv
module vseq_offs_ctr #(
   parameter int OFFS_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              inc_i,
   input  logic [OFFS_W-1:0] limit_i,
   output logic [OFFS_W-1:0] cnt_o,
   output logic              last_o
);
   localparam logic [OFFS_W-1:0] ONE = OFFS_W'(1);

   logic [OFFS_W-1:0] cnt_q;
   logic [OFFS_W-1:0] cnt_p1;

   assign cnt_p1 = cnt_q + ONE;
   assign last_o = (cnt_p1 == limit_i);
   assign cnt_o  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clr_i) cnt_q <= '0;
      else if (inc_i) cnt_q <= cnt_p1;
   end
endmodule

// File: rtl/vseq_sub_ctr.sv
module vseq_sub_ctr #(
   parameter int SW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          step_i,
   input  logic [SW-1:0] last_code_i,
   output logic [SW-1:0] sub_o,
   output logic          at_last_o
);
   logic [SW-1:0] sub_q;

   assign at_last_o = (sub_q == last_code_i);
   assign sub_o     = sub_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sub_q <= '0;
      else if (clr_i)  sub_q <= '0;
      else if (step_i) sub_q <= at_last_o ? '0 : sub_q + SW'(1);
   end
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
   import vseq_pkg::*;
#(
   parameter int MAXVL  = 16,
   parameter int IDX_W  = $clog2(MAXVL),
   parameter int OFFS_W = $clog2(MAXVL + 1),
   parameter int VLI_W  = OFFS_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [VLI_W-1:0]  vl_i,
   input  logic [1:0]        subvl_i,
   input  logic              dst_pen_i,
   input  logic [MAXVL-1:0]  dst_mask_i,
   input  logic              dst_inv_i,
   input  logic              src_pen_i,
   input  logic [MAXVL-1:0]  src_mask_i,
   input  logic              src_inv_i,
   input  logic              zeroing_i,
   input  logic              ffirst_i,
   input  logic              ready_i,
   input  logic              fail_i,
   output logic              busy_o,
   output logic              step_valid_o,
   output logic              step_zero_o,
   output logic [IDX_W-1:0]  src_offs_o,
   output logic [IDX_W-1:0]  dst_offs_o,
   output logic [1:0]        sub_offs_o,
   output logic              done_o,
   output logic [OFFS_W-1:0] eff_vl_o
);
   localparam int NSIDE = 2;   // index 0: source, 1: destination

   if (MAXVL < 2) begin : g_bad_maxvl
      $error("vec_elem_seq: MAXVL must be at least 2");
   end
   if (IDX_W != $clog2(MAXVL) || OFFS_W != $clog2(MAXVL + 1)) begin : g_bad_width
      $error("vec_elem_seq: derived widths must not be overridden");
   end

   seq_state_e state_q, state_d;
   step_act_e  act;

   logic [OFFS_W-1:0] vl_q;
   logic [SUB_W-1:0]  subvl_q;
   logic [MAXVL-1:0]  mask_q [NSIDE];
   logic              pen_q  [NSIDE];
   logic              inv_q  [NSIDE];
   logic              zero_q, ff_q;
   logic [OFFS_W-1:0] eff_q;

   logic [OFFS_W-1:0] vl_clamped;
   logic              accept;

   logic [OFFS_W-1:0] cnt   [NSIDE];
   logic              last  [NSIDE];
   logic              inc   [NSIDE];
   logic              pbit  [NSIDE];
   logic [SUB_W-1:0]  sub_cnt;
   logic              sub_last;

   logic run, adv, emit, fail_hit, grp_end, sub_step, end_hit;

   // ---------------- configuration capture ----------------
   assign accept = (state_q == ST_IDLE) && start_i;

   always_comb begin
      if (vl_i == '0)                        vl_clamped = OFFS_W'(1);
      else if (vl_i > VLI_W'(MAXVL))         vl_clamped = OFFS_W'(MAXVL);
      else                                   vl_clamped = vl_i[OFFS_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vl_q    <= OFFS_W'(1);
         subvl_q <= '0;
         zero_q  <= 1'b0;
         ff_q    <= 1'b0;
         for (int s = 0; s < NSIDE; s++) begin
            mask_q[s] <= '0;
            pen_q[s]  <= 1'b0;
            inv_q[s]  <= 1'b0;
         end
      end else if (accept) begin
         vl_q      <= vl_clamped;
         subvl_q   <= subvl_i;
         zero_q    <= zeroing_i;
         ff_q      <= ffirst_i;
         mask_q[0] <= src_mask_i;
         pen_q[0]  <= src_pen_i;
         inv_q[0]  <= src_inv_i;
         mask_q[1] <= dst_mask_i;
         pen_q[1]  <= dst_pen_i;
         inv_q[1]  <= dst_inv_i;
      end
   end

   // ---------------- per-side offset and predicate ----------------
   for (genvar g = 0; g < NSIDE; g++) begin : g_side
      vseq_offs_ctr #(.OFFS_W(OFFS_W)) u_ctr (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr_i   (accept),
         .inc_i   (inc[g]),
         .limit_i (vl_q),
         .cnt_o   (cnt[g]),
         .last_o  (last[g])
      );

      vseq_pred_bit #(.MAXVL(MAXVL), .OFFS_W(OFFS_W)) u_pred (
         .en_i   (pen_q[g]),
         .inv_i  (inv_q[g]),
         .mask_i (mask_q[g]),
         .idx_i  (cnt[g]),
         .bit_o  (pbit[g])
      );
   end

   vseq_sub_ctr #(.SW(SUB_W)) u_sub (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (accept),
      .step_i      (sub_step),
      .last_code_i (subvl_q),
      .sub_o       (sub_cnt),
      .at_last_o   (sub_last)
   );

   // ---------------- step decision ----------------
   always_comb begin
      if (pbit[1] && pbit[0])  act = ACT_ISSUE;
      else if (!pbit[1])       act = zero_q ? ACT_ZERO : ACT_SKIP_DST;
      else                     act = ACT_SKIP_SRC;
   end

   assign run      = (state_q == ST_RUN);
   assign adv      = run && ready_i;
   assign emit     = run && (act == ACT_ISSUE || act == ACT_ZERO);
   assign fail_hit = adv && (act == ACT_ISSUE) && ff_q && fail_i;
   assign sub_step = emit && adv && !fail_hit;
   assign grp_end  = sub_step && sub_last;

   assign inc[1]  = grp_end || (adv && act == ACT_SKIP_DST);
   assign inc[0]  = (grp_end && act == ACT_ISSUE) || (adv && act == ACT_SKIP_SRC);
   assign end_hit = (inc[1] && last[1]) || (inc[0] && last[0]);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (start_i)             state_d = ST_RUN;
         ST_RUN:  if (fail_hit || end_hit) state_d = ST_FIN;
         ST_FIN:                           state_d = ST_IDLE;
         default:                          state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         eff_q   <= '0;
      end else begin
         state_q <= state_d;
         if (fail_hit)     eff_q <= cnt[1];
         else if (end_hit) eff_q <= vl_q;
      end
   end

   // ---------------- outputs ----------------
   assign busy_o       = (state_q != ST_IDLE);
   assign done_o       = (state_q == ST_FIN);
   assign step_valid_o = emit;
   assign step_zero_o  = run && (act == ACT_ZERO);
   assign src_offs_o   = cnt[0][IDX_W-1:0];
   assign dst_offs_o   = cnt[1][IDX_W-1:0];
   assign sub_offs_o   = sub_cnt;
   assign eff_vl_o     = eff_q;

endmodule

// File: rtl/vseq_chk.sv
module vseq_chk #(
   parameter int OFFS_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              step_valid,
   input logic              step_zero,
   input logic              ready,
   input logic [OFFS_W-1:0] dst_cnt,
   input logic [OFFS_W-1:0] src_cnt,
   input logic [1:0]        sub_cnt,
   input logic [1:0]        subvl_q,
   input logic [OFFS_W-1:0] vl_q,
   input logic [OFFS_W-1:0] eff_vl
);
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!step_valid && !done));

   assert_sub_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      step_valid |-> (sub_cnt <= subvl_q));

   assert_dst_monotone_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> (dst_cnt == $past(dst_cnt) || dst_cnt == $past(dst_cnt) + OFFS_W'(1)));

   assert_zero_is_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      step_zero |-> step_valid);

   assert_offs_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |-> (dst_cnt < vl_q && src_cnt < vl_q));

   assert_eff_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (eff_vl <= vl_q));

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (step_valid && !ready) |=> (step_valid && $stable(dst_cnt) && $stable(src_cnt) && $stable(sub_cnt)));
endmodule

bind vec_elem_seq vseq_chk #(.OFFS_W(OFFS_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy_o),
   .done       (done_o),
   .step_valid (step_valid_o),
   .step_zero  (step_zero_o),
   .ready      (ready_i),
   .dst_cnt    (cnt[1]),
   .src_cnt    (cnt[0]),
   .sub_cnt    (sub_cnt),
   .subvl_q    (subvl_q),
   .vl_q       (vl_q),
   .eff_vl     (eff_q)
);

// File: tb/tb_vec_elem_seq.sv
`timescale 1ns/1ps
module tb_vec_elem_seq;
   localparam int MAXVL = 16;

   typedef struct packed {
      logic [5:0]  vl;
      logic [1:0]  sub;
      logic        den;
      logic [15:0] dmask;
      logic        dinv;
      logic        sen;
      logic [15:0] smask;
      logic        sinv;
      logic        zero;
      logic        ff;
      logic [5:0]  fail_at;
      logic [7:0]  n_iss;
      logic [7:0]  n_zero;
      logic [5:0]  eff;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t TBL [NV] = '{
      '{6'd1,  2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 6'd63, 8'd1,  8'd0,  6'd1},
      '{6'd4,  2'd3, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 6'd63, 8'd16, 8'd0,  6'd4},
      '{6'd8,  2'd1, 1'b1, 16'h00A5, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 6'd63, 8'd8,  8'd0,  6'd8},
      '{6'd8,  2'd0, 1'b1, 16'h0007, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 6'd63, 8'd5,  8'd0,  6'd8},
      '{6'd6,  2'd2, 1'b1, 16'h0009, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 6'd63, 8'd6,  8'd12, 6'd6},
      '{6'd8,  2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 6'd3,  8'd4,  8'd0,  6'd3},
      '{6'd8,  2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 6'd3,  8'd8,  8'd0,  6'd8},
      '{6'd8,  2'd1, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 6'd2,  8'd5,  8'd0,  6'd2},
      '{6'd4,  2'd0, 1'b1, 16'h000C, 1'b0, 1'b1, 16'h0005, 1'b0, 1'b0, 1'b0, 6'd63, 8'd2,  8'd0,  6'd4},
      '{6'd5,  2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 6'd0,  8'd1,  8'd0,  6'd0},
      '{6'd0,  2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 6'd63, 8'd1,  8'd0,  6'd1},
      '{6'd20, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 6'd63, 8'd16, 8'd0,  6'd16},
      '{6'd4,  2'd0, 1'b1, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 6'd63, 8'd0,  8'd0,  6'd4},
      '{6'd4,  2'd0, 1'b1, 16'h000C, 1'b0, 1'b1, 16'h0005, 1'b0, 1'b1, 1'b0, 6'd63, 8'd2,  8'd2,  6'd4},
      '{6'd4,  2'd0, 1'b1, 16'h000B, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 6'd2,  8'd3,  8'd1,  6'd4}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [5:0]  vl_i = '0;
   logic [1:0]  subvl_i = '0;
   logic        dst_pen_i = 1'b0, dst_inv_i = 1'b0, src_pen_i = 1'b0, src_inv_i = 1'b0;
   logic [15:0] dst_mask_i = '0, src_mask_i = '0;
   logic        zeroing_i = 1'b0, ffirst_i = 1'b0, ready_i = 1'b0, fail_i = 1'b0;
   logic        busy_o, step_valid_o, step_zero_o, done_o;
   logic [3:0]  src_offs_o, dst_offs_o;
   logic [1:0]  sub_offs_o;
   logic [4:0]  eff_vl_o;

   vec_elem_seq #(.MAXVL(MAXVL)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i), .subvl_i(subvl_i),
      .dst_pen_i(dst_pen_i), .dst_mask_i(dst_mask_i), .dst_inv_i(dst_inv_i),
      .src_pen_i(src_pen_i), .src_mask_i(src_mask_i), .src_inv_i(src_inv_i),
      .zeroing_i(zeroing_i), .ffirst_i(ffirst_i), .ready_i(ready_i), .fail_i(fail_i),
      .busy_o(busy_o), .step_valid_o(step_valid_o), .step_zero_o(step_zero_o),
      .src_offs_o(src_offs_o), .dst_offs_o(dst_offs_o), .sub_offs_o(sub_offs_o),
      .done_o(done_o), .eff_vl_o(eff_vl_o)
   );

   always #10 clk = ~clk;   // 50 MHz

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;
   int pat      = 0;

   // results of the last run
   int   r_iss, r_zero, r_gap, r_bad;
   logic [5:0] r_eff;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic bit pbit(input logic en, input logic [15:0] m, input logic inv, input int idx);
      return en ? (m[idx] ^ inv) : 1'b1;
   endfunction

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
         finish_run();
      end
   end

   // Runs one job; called and returns at a negedge. done_o is high on return.
   task automatic run_one(input vec_t v, input bit use_pat, input bit disturb);
      int  pd, ps, have;
      bit  last_acc;
      r_iss = 0; r_zero = 0; r_gap = 0; r_bad = 0; r_eff = '0;
      have = 0; pd = 0; ps = 0; last_acc = 1'b0;
      vl_i = v.vl; subvl_i = v.sub;
      dst_pen_i = v.den; dst_mask_i = v.dmask; dst_inv_i = v.dinv;
      src_pen_i = v.sen; src_mask_i = v.smask; src_inv_i = v.sinv;
      zeroing_i = v.zero; ffirst_i = v.ff; ready_i = 1'b1; fail_i = 1'b0;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int k = 0; k < 600; k++) begin
         if (done_o) begin
            r_eff = 6'(eff_vl_o);
            return;
         end
         if (disturb && k == 0) begin
            start_i = 1'b1; vl_i = 6'd10; dst_pen_i = 1'b1; dst_mask_i = '0; subvl_i = 2'd3;
         end else if (disturb && k == 1) begin
            start_i = 1'b0;
         end
         pat++;
         ready_i = use_pat ? ((pat % 5) != 4) : 1'b1;
         fail_i  = step_valid_o && (6'(dst_offs_o) == v.fail_at);
         r_gap = last_acc ? 1 : r_gap + 1;
         last_acc = 1'b0;
         if (step_valid_o && ready_i) begin
            last_acc = 1'b1;
            if (step_zero_o) begin
               r_zero++;
               if (pbit(v.den, v.dmask, v.dinv, int'(dst_offs_o)) != 1'b0) r_bad++;
            end else begin
               r_iss++;
               if (pbit(v.den, v.dmask, v.dinv, int'(dst_offs_o)) != 1'b1) r_bad++;
               if (pbit(v.sen, v.smask, v.sinv, int'(src_offs_o)) != 1'b1) r_bad++;
            end
            if (have != 0 && int'(dst_offs_o) == pd) begin
               if (int'(sub_offs_o) != ps + 1) r_bad++;
            end else begin
               if (sub_offs_o != 2'd0) r_bad++;
               if (have != 0 && int'(dst_offs_o) < pd) r_bad++;
            end
            have = 1; pd = int'(dst_offs_o); ps = int'(sub_offs_o);
         end
         @(negedge clk);
      end
      r_bad++;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(busy_o == 1'b0,       "R1", "busy in reset", int'(busy_o), 0);
      chk(step_valid_o == 1'b0, "R1", "step_valid in reset", int'(step_valid_o), 0);
      chk(done_o == 1'b0,       "R1", "done in reset", int'(done_o), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(busy_o == 1'b0, "R1", "idle without start", int'(busy_o), 0);

      // Table walk: R3 ordering, R4 predicate, R5 zeroing, R6 twin, R7 ffirst, R10 clamp
      for (int i = 0; i < NV; i++) begin
         run_one(TBL[i], 1'b1, 1'b0);
         chk(r_iss == int'(TBL[i].n_iss),   "R3/R4/R6", $sformatf("vec %0d issue steps", i), r_iss, int'(TBL[i].n_iss));
         chk(r_zero == int'(TBL[i].n_zero), "R5", $sformatf("vec %0d zero steps", i), r_zero, int'(TBL[i].n_zero));
         chk(r_eff == TBL[i].eff,           "R7/R8/R10", $sformatf("vec %0d eff_vl", i), int'(r_eff), int'(TBL[i].eff));
         chk(r_bad == 0,                    "R3/R4", $sformatf("vec %0d order/predicate errors", i), r_bad, 0);
         @(negedge clk);
      end

      // R9: stall holds outputs
      begin
         logic [3:0] hd, hs;
         logic [1:0] hb;
         vl_i = 6'd4; subvl_i = 2'd3; dst_pen_i = 1'b0; src_pen_i = 1'b0;
         zeroing_i = 1'b0; ffirst_i = 1'b0; fail_i = 1'b0; ready_i = 1'b1;
         start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
         @(negedge clk);
         ready_i = 1'b0;
         hd = dst_offs_o; hs = src_offs_o; hb = sub_offs_o;
         chk(hb == 2'd1, "R3", "sub offset after one step", int'(hb), 1);
         for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(step_valid_o && dst_offs_o == hd && src_offs_o == hs && sub_offs_o == hb,
                "R9", "hold while ready low", int'(sub_offs_o), int'(hb));
         end
         ready_i = 1'b1;
         for (int k = 0; k < 40 && !done_o; k++) @(negedge clk);
         chk(done_o == 1'b1, "R9", "run completes after stall", int'(done_o), 1);
         @(negedge clk);
      end

      // R2: start and input changes during a run are ignored
      begin
         vec_t d;
         d = TBL[0];
         d.vl = 6'd3;
         run_one(d, 1'b0, 1'b1);
         chk(r_iss == 3,     "R2", "issue steps with mid-run disturbance", r_iss, 3);
         chk(r_eff == 6'd3,  "R2", "eff_vl with mid-run disturbance", int'(r_eff), 3);
         chk(r_bad == 0,     "R2", "order with mid-run disturbance", r_bad, 0);
         @(negedge clk);
         chk(busy_o == 1'b0, "R2", "no second run from ignored start", int'(busy_o), 0);
      end

      // R7/R8: done timing after a failure and pulse width
      begin
         vec_t d;
         d = TBL[5];
         d.vl = 6'd6; d.fail_at = 6'd1;
         run_one(d, 1'b0, 1'b0);
         chk(r_iss == 2,    "R7", "steps up to failing element", r_iss, 2);
         chk(r_eff == 6'd1, "R7", "eff_vl equals failing index", int'(r_eff), 1);
         chk(r_gap == 1,    "R8", "done one cycle after failing step", r_gap, 1);
         @(negedge clk);
         chk(done_o == 1'b0 && busy_o == 1'b0, "R8", "done lasts one cycle", int'(done_o), 0);
      end

      finish_run();
   end
endmodule